// File: doc/BRIEF.md
# Grouped Interrupt Control Register Bank

This block holds the control state of a grouped interrupt controller. By default it has 31 groups, each with four request lines. The lowest groups (two by default) are non-maskable. Their enable mask is fixed at all ones. An incoming request on one of them produces a one-cycle NMI pulse. Every other group is maskable and carries a 4-bit enable mask and a 3-bit priority level, both set by software.

Software reaches the state through a byte-wide register bus. Each group owns four consecutive byte addresses. Request bits are set by single-cycle pulses from upstream trigger logic. Software clears or sets them through writes, and the write encoding depends on the group kind. The block does no trigger detection and no priority arbitration. It only exports, for each group, the pending vector (request AND enable) and the level, for a downstream resolver to use.

Top module: `grp_irq_regs`

## Requirements
- R1: A bus address selects group `addr[ADDR_W-1:2]` and byte `addr[1:0]`. An address whose group index is at or above the group count reads 0, and writes to it change nothing. With the default parameters, addresses 124 to 127 are such addresses and group 30 is the top group.
- R2: For a maskable group, a read of byte 0 returns the raw request nibble in bits 7:4 and (request AND enable) in bits 3:0.
- R3: For a maskable group, a write to byte 0 acts on each request bit i as follows. With data bits i+4 and i both 1, the bit is set. With bit i+4 at 0 and bit i at 1, the bit is cleared. In all other cases the bit is left as it is.
- R4: For a maskable group, byte 1 holds the level in bits 6:4 and the enable mask in bits 3:0. Both fields can be written and read back, and bit 7 reads as 0. The level appears on `level_vec[3g+2:3g]`, and the level outputs change only on a bus write.
- R5: For a non-maskable group, a read of byte 0 returns the request nibble in bits 3:0, with bits 7:4 at 0. Writing byte 0 clears every request bit written as 1.
- R6: For a non-maskable group, writing byte 3 sets every request bit written as 1.
- R7: After reset, all request bits and levels are 0, maskable enables are 0, and non-maskable enables are 0xF.
- R8: `nmi_out` is high for exactly the cycle after a cycle in which a request pulse reaches an enabled line of a non-maskable group. Software writes never raise it.
- R9: The bytes not listed in R2 to R6 read 0, and writes to them are ignored. `bus_rdata` is registered: it shows the read result in the cycle after `bus_rd` and is 0 otherwise.
- R10: If a request pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R11: A request pulse on line `4g+i` sets request bit i of group g whatever the enable. `pend_vec[4g+i]` equals request AND enable, and for non-maskable groups it equals the request itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_pulse | input | 4*GROUPS | Request pulses, line 4g+i = group g input i |
| nmi_out | output | 1 | One-cycle non-maskable interrupt pulse |
| pend_vec | output | 4*GROUPS | Request AND enable per group |
| level_vec | output | 3*GROUPS | Priority level per group |

## Verification
The bench uses the default build: 31 groups, two of them non-maskable, and a 7-bit address. With these values the top group 30 can be reached, and so can the four unmapped addresses 124 to 127 that lie past it. Both group kinds are exercised, including a same-cycle collision on a non-maskable group and on a maskable group. Expected read bytes are queued by the driver and compared by a monitor when the registered read data appears.

// File: rtl/grp_irq_regs.sv
module grp_irq_regs #(
  parameter int GROUPS     = 31,
  parameter int NMI_GROUPS = 2,
  parameter int ADDR_W     = $clog2(GROUPS * 4)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [7:0]            bus_wdata,
  output logic [7:0]            bus_rdata,
  input  logic [GROUPS*4-1:0]   irq_pulse,
  output logic                  nmi_out,
  output logic [GROUPS*4-1:0]   pend_vec,
  output logic [GROUPS*3-1:0]   level_vec
);
  localparam int LINES = 4;
  localparam int LVL_W = 3;
  localparam int GI_W  = ADDR_W - 2;
  localparam int RQ_W  = GROUPS * LINES;

  logic [GI_W-1:0]             sel_grp;
  logic [1:0]                  sel_byte;
  logic [GROUPS-1:0][7:0]      rd_byte;
  logic [GROUPS-1:0]           nmi_ev;
  logic [RQ_W-1:0]             req_all;
  logic [7:0]                  rd_next;

  assign sel_grp  = bus_addr[ADDR_W-1:2];
  assign sel_byte = bus_addr[1:0];

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic             hit;
    logic [LINES-1:0] req_q;
    logic [LINES-1:0] en;
    logic [LVL_W-1:0] lvl;
    logic [LINES-1:0] pulse;

    assign hit   = (32'(sel_grp) == g);
    assign pulse = irq_pulse[g*LINES +: LINES];

    if (g < NMI_GROUPS) begin : g_nmi
      logic [LINES-1:0] clr, set;
      assign clr = (bus_wr && hit && sel_byte == 2'd0) ? bus_wdata[3:0] : '0;
      assign set = (bus_wr && hit && sel_byte == 2'd3) ? bus_wdata[3:0] : '0;
      assign en  = '1;
      assign lvl = '0;

      always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= (req_q & ~clr) | set | pulse;
      end

      assign rd_byte[g] = (sel_byte == 2'd0) ? {4'h0, req_q} : 8'h00;
      assign nmi_ev[g]  = |(pulse & en);
    end else begin : g_mask
      logic             wr0, wr1;
      logic [LINES-1:0] clr, set;
      logic [LINES-1:0] en_q;
      logic [LVL_W-1:0] lvl_q;

      assign wr0 = bus_wr && hit && sel_byte == 2'd0;
      assign wr1 = bus_wr && hit && sel_byte == 2'd1;
      assign set = wr0 ? (bus_wdata[3:0] &  bus_wdata[7:4]) : '0;
      assign clr = wr0 ? (bus_wdata[3:0] & ~bus_wdata[7:4]) : '0;
      assign en  = en_q;
      assign lvl = lvl_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          req_q <= '0;
          en_q  <= '0;
          lvl_q <= '0;
        end else begin
          req_q <= (req_q & ~clr) | set | pulse;
          if (wr1) begin
            en_q  <= bus_wdata[3:0];
            lvl_q <= bus_wdata[6:4];
          end
        end
      end

      always_comb begin
        case (sel_byte)
          2'd0:    rd_byte[g] = {req_q, req_q & en_q};
          2'd1:    rd_byte[g] = {1'b0, lvl_q, en_q};
          default: rd_byte[g] = 8'h00;
        endcase
      end
      assign nmi_ev[g] = 1'b0;
    end

    assign req_all[g*LINES +: LINES]  = req_q;
    assign pend_vec[g*LINES +: LINES] = req_q & en;
    assign level_vec[g*LVL_W +: LVL_W] = lvl;
  end

  always_comb begin
    rd_next = 8'h00;
    for (int g = 0; g < GROUPS; g++)
      if (32'(sel_grp) == g) rd_next = rd_byte[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= 8'h00;
      nmi_out   <= 1'b0;
    end else begin
      bus_rdata <= bus_rd ? rd_next : 8'h00;
      nmi_out   <= |nmi_ev;
    end
  end
endmodule

// File: rtl/grp_irq_regs_chk.sv
module grp_irq_regs_chk #(
  parameter int RQ_W      = 124,
  parameter int LV_W      = 93,
  parameter int NMI_LINES = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [7:0]      bus_rdata,
  input logic [RQ_W-1:0] irq_pulse,
  input logic            nmi_out,
  input logic [RQ_W-1:0] pend_vec,
  input logic [LV_W-1:0] level_vec,
  input logic [RQ_W-1:0] req_all
);
  for (genvar k = 0; k < RQ_W; k++) begin : g_bit
    p_pulse_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse[k] |=> req_all[k]);
  end

  p_pend_subset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vec & ~req_all) == '0);

  p_nmi_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_pulse[NMI_LINES-1:0]) |=> nmi_out);

  p_nmi_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|irq_pulse[NMI_LINES-1:0]) |=> !nmi_out);

  p_level_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(level_vec));

  p_rd_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == 8'h00);
endmodule

bind grp_irq_regs grp_irq_regs_chk #(
  .RQ_W(RQ_W), .LV_W(GROUPS*3), .NMI_LINES(NMI_GROUPS*4)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .irq_pulse(irq_pulse), .nmi_out(nmi_out),
  .pend_vec(pend_vec), .level_vec(level_vec), .req_all(req_all)
);

// File: tb/grp_irq_regs_bench.sv
`timescale 1ns/1ps
module grp_irq_regs_bench;
  localparam int G = 31;
  localparam int AW = 7;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 0, bus_rd = 0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [G*4-1:0] irq_pulse = '0;
  logic          nmi_out;
  logic [G*4-1:0] pend_vec;
  logic [G*3-1:0] level_vec;

  int checks = 0, errors = 0;
  bit done = 0;
  byte unsigned exp_q[$];
  string tag_q[$];
  bit rd_issued = 0, rd_due = 0;

  always #4 clk = ~clk;

  grp_irq_regs u_grp_irq_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pulse(irq_pulse), .nmi_out(nmi_out), .pend_vec(pend_vec),
    .level_vec(level_vec)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_due <= rd_issued;

  always @(negedge clk) begin
    if (rd_due) begin
      if (exp_q.size() == 0) check("R9 unexpected read", 1, 0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end else if (rst_n && bus_rdata !== 8'h00) begin
      check("R9 idle rdata", bus_rdata, 0);
    end
  end

  task automatic rd(input int g, input int b, input byte unsigned exp, input string tag);
    bus_addr = AW'(g*4 + b); bus_rd = 1; rd_issued = 1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 0; rd_issued = 0;
    @(negedge clk);
  endtask

  task automatic wr(input int a, input byte unsigned d, input logic [G*4-1:0] p = '0);
    bus_addr = AW'(a); bus_wdata = d; bus_wr = 1; irq_pulse = p;
    @(negedge clk);
    bus_wr = 0; irq_pulse = '0;
  endtask

  task automatic pulse(input logic [G*4-1:0] p);
    irq_pulse = p;
    @(negedge clk);
    irq_pulse = '0;
  endtask

  function automatic logic [G*4-1:0] ln(input int idx);
    logic [G*4-1:0] v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R7 reset state
    check("R7 pend after reset", pend_vec, 0);
    check("R7 level after reset", level_vec, 0);
    check("R7 nmi after reset", nmi_out, 0);
    rd(2, 1, 8'h00, "R7 maskable enable reset");
    rd(0, 0, 8'h00, "R7 nmi request reset");

    // R4 byte 1 level/enable
    wr(5*4+1, 8'hBA);
    rd(5, 1, 8'h3A, "R4 byte1 readback");
    check("R4 level output", level_vec[17:15], 3);

    // R2 / R11 request pulses
    pulse(ln(20) | ln(21));
    check("R11 pend masked", pend_vec[23:20], 4'b0010);
    rd(5, 0, 8'h32, "R2 byte0 format");

    // R3 masked write: set bit2, clear bit0, keep bits 1,3
    wr(5*4, 8'hC5);
    rd(5, 0, 8'h62, "R3 masked set/clear");
    wr(5*4, 8'hF0);
    rd(5, 0, 8'h62, "R3 no-op write");

    // R9 undefined bytes
    wr(5*4+2, 8'hFF);
    wr(5*4+3, 8'hFF);
    rd(5, 2, 8'h00, "R9 maskable byte2");
    rd(5, 3, 8'h00, "R9 maskable byte3");
    rd(5, 0, 8'h62, "R9 request untouched");
    rd(5, 1, 8'h3A, "R9 config untouched");

    // R11 maskable pulse with enable 0, no NMI
    irq_pulse = ln(11);
    @(negedge clk);
    irq_pulse = '0;
    check("R8 no nmi from maskable", nmi_out, 0);
    check("R11 pend with enable 0", pend_vec[11:8], 0);
    rd(2, 0, 8'h80, "R11 raw request recorded");

    // R8 / R5 NMI group
    irq_pulse = ln(6);
    @(negedge clk);
    irq_pulse = '0;
    check("R8 nmi pulse", nmi_out, 1);
    check("R11 nmi pend", pend_vec[7:4], 4'b0100);
    @(negedge clk);
    check("R8 nmi one cycle", nmi_out, 0);
    rd(1, 0, 8'h04, "R5 nmi byte0 read");
    wr(1*4, 8'h04);
    rd(1, 0, 8'h00, "R5 write one to clear");

    // R6 set byte
    wr(1*4+3, 8'h09);
    check("R8 no nmi from software set", nmi_out, 0);
    rd(1, 0, 8'h09, "R6 write one to set");
    rd(1, 3, 8'h00, "R9 nmi byte3 read");
    wr(1*4+1, 8'hFF);
    rd(1, 1, 8'h00, "R9 nmi byte1");
    rd(1, 0, 8'h09, "R9 nmi request untouched");

    // R10 pulse beats clear
    wr(1*4, 8'h09, ln(4));
    rd(1, 0, 8'h01, "R10 nmi collision");
    wr(5*4, 8'h02, ln(21));
    rd(5, 0, 8'h62, "R10 maskable collision");

    // R1 decode: top group and unmapped space
    wr(30*4+1, 8'h71);
    rd(30, 1, 8'h71, "R1 top group");
    check("R1 top level", level_vec[92:90], 7);
    wr(124, 8'hFF);
    wr(127, 8'hFF);
    rd(31, 0, 8'h00, "R1 unmapped 124");
    rd(31, 3, 8'h00, "R1 unmapped 127");
    rd(5, 1, 8'h3A, "R1 other group intact");
    rd(30, 0, 8'h00, "R1 top group request intact");

    repeat (2) @(negedge clk);
    check("R9 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule